// File: doc/BRIEF.md
# Saturating Doubling Multiply-Long Unit

This block is a scalar execution unit inside a SIMD datapath. Each operation comes as a 32-bit instruction word and three operand values: the low element of the first source, the low element of the second source, and the value the destination register holds now. The unit decodes the word into one of three signed operations:

- doubling multiply-long
- doubling multiply-accumulate-long
- doubling multiply-subtract-long

It also rejects every encoding outside those three. The result is 64 bits wide. Two element sizes are supported: 16-bit sources give a 32-bit result, and 32-bit sources give a 64-bit result.

The product of the two sign-extended sources is doubled with signed saturation at the result width. For the accumulate form, that doubled value is added to the old destination with a second signed-saturating add. For the subtract form, the doubled value is negated before that add. A sticky saturation flag records any clamp from either step until it is cleared. A request is accepted on an input valid strobe. Result, undefined-instruction flag and saturation flag are registered on that clock edge, and an output valid pulse lasts one cycle.

Top module: `sqdml_unit`

## Requirements
- R1: When instruction bit 29 is 1, the operation is flagged undefined, `undef_flag` is 1 and `result` is 0.
- R2: Only opcode values 0x9 (accumulate), 0xB (subtract) and 0xD (multiply only) in instruction bits 15:12 are accepted; every other opcode is flagged undefined with `result` 0.
- R3: Size values 0 and 3 in instruction bits 23:22 are flagged undefined for every opcode, with `result` 0. An undefined operation leaves `sat_flag` unchanged.
- R4: With size 1 and the multiply-only opcode, `result` is twice the signed product of `src_a[15:0]` and `src_b[15:0]`, saturated to 32 bits and zero-extended to 64 bits. Higher source bits have no effect.
- R5: With size 2 and the multiply-only opcode, `result` is twice the signed product of `src_a[31:0]` and `src_b[31:0]`, saturated to 64 bits.
- R6: When both sources hold the most negative value of their size, the doubling clamps. The clamped value is 0x7FFFFFFF for size 1 and 0x7FFFFFFFFFFFFFFF for size 2, and the clamp sets `sat_flag`.
- R7: The accumulate opcode adds the doubled and saturated product to the old destination with signed saturation. The old destination is read as `dst_in[31:0]` for size 1 and as all of `dst_in` for size 2. A size 1 result is zero-extended.
- R8: The subtract opcode negates the doubled and saturated product, then adds it to the old destination with the same signed saturation and read widths as R7.
- R9: `sat_flag` goes to 1 after any operation in which either saturating step clamps. It holds until `sat_clear` is 1 on a clock edge with no new clamp. A clamp in the same cycle as a clear leaves the flag at 1.
- R10: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1. `result` and `undef_flag` change only on edges where `in_valid` is 1.
- R11: While reset is held, `out_valid`, `result`, `sat_flag` and `undef_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Low element of first source |
| src_b | input | 32 | Low element of second source |
| dst_in | input | 64 | Current destination value (accumulator) |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | One-cycle pulse, result is valid |
| result | output | 64 | Destination value to write back |
| sat_flag | output | 1 | Sticky saturation flag |
| undef_flag | output | 1 | Operation was an undefined encoding |

## Verification
The unit has only one register stage. A wrong decode, lane choice or clamp therefore shows in `result` or `undef_flag` in the very cycle `out_valid` pulses for that request. A wrong sticky flag shows at `sat_flag` in that same cycle, or on the edge after a clear. The corners that expose faults are the most-negative operands and accumulators just inside the saturation limits of each size. Set upper bits in the source and accumulator words also catch a read of the wrong operand width.

// File: rtl/sqdml_pkg.sv
package sqdml_pkg;

    localparam int INSTR_W  = 32;

    // Instruction field positions
    localparam int UBIT_POS = 29;
    localparam int SIZE_LSB = 22;
    localparam int OPC_LSB  = 12;

    localparam logic [3:0] OPC_ACC = 4'h9;
    localparam logic [3:0] OPC_SUB = 4'hB;
    localparam logic [3:0] OPC_MUL = 4'hD;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_ACC = 2'd1,
        OP_SUB = 2'd2
    } sqdml_op_e;

    typedef struct packed {
        logic      undef;
        logic      wide;    // 1: 32-bit sources, 0: 16-bit sources
        sqdml_op_e op;
    } sqdml_dec_t;

    function automatic sqdml_dec_t decode_word(input logic [INSTR_W-1:0] w);
        sqdml_dec_t d;
        logic [1:0] sz;
        logic [3:0] opc;
        sz      = w[SIZE_LSB +: 2];
        opc     = w[OPC_LSB +: 4];
        d.undef = w[UBIT_POS] | (sz == 2'd0) | (sz == 2'd3);
        d.wide  = (sz == 2'd2);
        unique case (opc)
            OPC_ACC: d.op = OP_ACC;
            OPC_SUB: d.op = OP_SUB;
            OPC_MUL: d.op = OP_MUL;
            default: begin
                d.op    = OP_MUL;
                d.undef = 1'b1;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sqdml_decode.sv
module sqdml_decode
    import sqdml_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output sqdml_dec_t         dec
);
    always_comb dec = decode_word(instr);
endmodule

// File: rtl/sqdml_lane.sv
module sqdml_lane
    import sqdml_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic [SRC_W-1:0]   a,
    input  logic [SRC_W-1:0]   b,
    input  logic [2*SRC_W-1:0] acc,
    input  sqdml_op_e          op,
    output logic [2*SRC_W-1:0] res,
    output logic               sat
);
    localparam int PW = 2 * SRC_W;

    // Returns {clamped, value}
    function automatic logic [PW:0] sat_add(input logic [PW-1:0] x, input logic [PW-1:0] y);
        logic [PW:0] s;
        s = {x[PW-1], x} + {y[PW-1], y};
        if (s[PW] != s[PW-1])
            return {1'b1, s[PW], {(PW-1){~s[PW]}}};
        return {1'b0, s[PW-1:0]};
    endfunction

    logic signed [PW-1:0] prod;
    logic [PW:0]          dbl;
    logic [PW-1:0]        term;
    logic [PW:0]          sum;

    always_comb begin
        prod = $signed({{SRC_W{a[SRC_W-1]}}, a}) * $signed({{SRC_W{b[SRC_W-1]}}, b});
        dbl  = sat_add(prod, prod);
        term = (op == OP_SUB) ? (~dbl[PW-1:0] + 1'b1) : dbl[PW-1:0];
        sum  = sat_add(acc, term);
        if (op == OP_MUL) begin
            res = dbl[PW-1:0];
            sat = dbl[PW];
        end else begin
            res = sum[PW-1:0];
            sat = dbl[PW] | sum[PW];
        end
    end
endmodule

// File: rtl/sqdml_unit.sv
module sqdml_unit
    import sqdml_pkg::*;
#(
    parameter int NARROW_W = 16,
    localparam int WIDE_W  = 2 * NARROW_W,
    localparam int RES_W   = 4 * NARROW_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [WIDE_W-1:0]  src_a,
    input  logic [WIDE_W-1:0]  src_b,
    input  logic [RES_W-1:0]   dst_in,
    input  logic               sat_clear,
    output logic               out_valid,
    output logic [RES_W-1:0]   result,
    output logic               sat_flag,
    output logic               undef_flag
);
    localparam int NLANE = 2;

    sqdml_dec_t       dec;
    logic [RES_W-1:0] lane_res [NLANE];
    logic             lane_sat [NLANE];
    logic [RES_W-1:0] sel_res;
    logic             sel_sat;

    sqdml_decode u_dec (.instr(instr), .dec(dec));

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
        logic [2*LW-1:0] r;
        logic            s;
        sqdml_lane #(.SRC_W(LW)) u_lane (
            .a   (src_a[LW-1:0]),
            .b   (src_b[LW-1:0]),
            .acc (dst_in[2*LW-1:0]),
            .op  (dec.op),
            .res (r),
            .sat (s)
        );
        assign lane_res[g] = RES_W'(r);
        assign lane_sat[g] = s;
    end

    always_comb begin
        sel_res = dec.wide ? lane_res[1] : lane_res[0];
        sel_sat = dec.wide ? lane_sat[1] : lane_sat[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            sat_flag   <= 1'b0;
            undef_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= dec.undef ? '0 : sel_res;
                undef_flag <= dec.undef;
            end
            sat_flag <= (sat_flag & ~sat_clear) | (in_valid & ~dec.undef & sel_sat);
        end
    end
endmodule

// File: rtl/sqdml_unit_chk.sv
module sqdml_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        sat_clear,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        sat_flag,
    input logic        undef_flag
);
    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(undef_flag)));
    // R1
    ubit_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[29]) |=> undef_flag);
    // R3
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && undef_flag) |-> (result == 64'd0));
    // R4
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[23:22] == 2'd1) |=> (result[63:32] == 32'd0));
    // R9
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clear) |=> sat_flag);
    // R9
    sat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_clear && !in_valid) |=> !sat_flag);
endmodule

bind sqdml_unit sqdml_unit_chk u_chk (.*);

// File: tb/sqdml_unit_tb.sv
`timescale 1ns/1ps
module sqdml_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [63:0] dst_in = '0;
    logic        sat_clear = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        sat_flag;
    logic        undef_flag;

    int checks = 0;
    int failures = 0;
    bit exp_sat = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sqdml_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .dst_in(dst_in), .sat_clear(sat_clear),
        .out_valid(out_valid), .result(result), .sat_flag(sat_flag),
        .undef_flag(undef_flag)
    );

    // Stimulus table: {U, size, opcode, src_a, src_b, dst_in}
    localparam int NV = 14;
    localparam logic [134:0] TBL [NV] = '{
        {1'b0, 2'd1, 4'hD, 32'h0000_8000, 32'h0000_8000, 64'h0},
        {1'b0, 2'd2, 4'hD, 32'h8000_0000, 32'h8000_0000, 64'h0},
        {1'b0, 2'd1, 4'hD, 32'hABCD_0003, 32'h1234_FFFB, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 2'd2, 4'hD, 32'h7FFF_FFFF, 32'h8000_0000, 64'h0},
        {1'b0, 2'd1, 4'h9, 32'h0000_0100, 32'h0000_0010, 64'h0000_0000_7FFF_F000},
        {1'b0, 2'd1, 4'h9, 32'h0000_0002, 32'h0000_0003, 64'hDEAD_BEEF_0000_0010},
        {1'b0, 2'd1, 4'hB, 32'h0000_0100, 32'h0000_0100, 64'h0000_0000_8000_0100},
        {1'b0, 2'd1, 4'hB, 32'h0000_8000, 32'h0000_8000, 64'h0},
        {1'b0, 2'd1, 4'h9, 32'h0000_8000, 32'h0000_8000, 64'h0000_0000_8000_0000},
        {1'b0, 2'd2, 4'h9, 32'h0001_0000, 32'h0001_0000, 64'h7FFF_FFFF_0000_0000},
        {1'b0, 2'd2, 4'h9, 32'hFFFF_FFFF, 32'h0000_0005, 64'h0000_0000_0000_0064},
        {1'b0, 2'd2, 4'hB, 32'h4000_0000, 32'h4000_0000, 64'h8000_0000_0000_0000},
        {1'b0, 2'd2, 4'hB, 32'h8000_0000, 32'h8000_0000, 64'h0000_0000_0000_0001},
        {1'b0, 2'd2, 4'h9, 32'h8000_0000, 32'h8000_0000, 64'h0000_0000_0000_0001}
    };

    function automatic logic [31:0] mk_instr(input bit u, input logic [1:0] sz, input logic [3:0] opc);
        logic [31:0] w;
        w = 32'h5E20_0000 & ~(32'h1 << 29);
        w[29] = u;
        w[23:22] = sz;
        w[20:16] = 5'd7;
        w[15:12] = opc;
        w[9:5] = 5'd3;
        w[4:0] = 5'd1;
        return w;
    endfunction

    function automatic logic signed [127:0] clampw(input logic signed [127:0] v, input int w, inout bit s);
        logic signed [127:0] hi, lo;
        hi = (128'sd1 <<< (w - 1)) - 128'sd1;
        lo = -(128'sd1 <<< (w - 1));
        if (v > hi) begin s = 1'b1; return hi; end
        if (v < lo) begin s = 1'b1; return lo; end
        return v;
    endfunction

    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [63:0] d, output logic [63:0] r, output bit u, output bit s);
        logic [1:0] sz;
        logic [3:0] opc;
        int w;
        logic signed [127:0] pa, pb, dbl, acc, sum;
        sz = ins[23:22];
        opc = ins[15:12];
        s = 1'b0;
        u = ins[29] || (sz == 2'd0) || (sz == 2'd3) ||
            !(opc == 4'h9 || opc == 4'hB || opc == 4'hD);
        r = '0;
        if (u) return;
        if (sz == 2'd1) begin
            pa = $signed(a[15:0]);
            pb = $signed(b[15:0]);
            acc = $signed(d[31:0]);
            w = 32;
        end else begin
            pa = $signed(a);
            pb = $signed(b);
            acc = $signed(d);
            w = 64;
        end
        dbl = clampw(2 * pa * pb, w, s);
        if (opc == 4'hD) sum = dbl;
        else if (opc == 4'hB) sum = clampw(acc - dbl, w, s);
        else sum = clampw(acc + dbl, w, s);
        r = (w == 32) ? {32'd0, sum[31:0]} : sum[63:0];
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request; samples at the negedge after the capturing edge.
    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [63:0] d, input bit clr, input string tag);
        logic [63:0] er;
        bit eu, es;
        model(ins, a, b, d, er, eu, es);
        @(negedge clk);
        instr = ins; src_a = a; src_b = b; dst_in = d;
        in_valid = 1'b1; sat_clear = clr;
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b0;
        exp_sat = (exp_sat & ~clr) | es;
        check({tag, " R10 out_valid"}, 64'(out_valid), 64'd1);
        check({tag, " result"}, result, er);
        check({tag, " undef"}, 64'(undef_flag), 64'(eu));
        check({tag, " R9 sat_flag"}, 64'(sat_flag), 64'(exp_sat));
    endtask

    task automatic clear_sat;
        @(negedge clk);
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
        exp_sat = 1'b0;
        check("R9 clear", 64'(sat_flag), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_valid", 64'(out_valid), 64'd0);
        check("R11 result", result, 64'd0);
        check("R11 sat_flag", 64'(sat_flag), 64'd0);
        check("R11 undef", 64'(undef_flag), 64'd0);
        rst = 1'b0;

        // Table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [134:0] e;
            string tag;
            e = TBL[i];
            if (e[133:132] == 2'd1 && e[131:128] == 4'hD) tag = "R4";
            else if (e[131:128] == 4'hD) tag = "R5";
            else if (e[131:128] == 4'h9) tag = "R7";
            else tag = "R8";
            if (e[127:96] == 32'h8000_0000 || e[111:96] == 16'h8000) tag = {tag, "/R6"};
            issue(mk_instr(e[134], e[133:132], e[131:128]), e[127:96], e[95:64], e[63:0], 1'b0, tag);
            clear_sat();
        end

        // R6: exact clamp values and flag
        issue(mk_instr(0, 2'd1, 4'hD), 32'h8000, 32'h8000, 64'h0, 1'b0, "R6 narrow");
        check("R6 narrow value", result, 64'h0000_0000_7FFF_FFFF);
        check("R6 narrow flag", 64'(sat_flag), 64'd1);
        clear_sat();
        issue(mk_instr(0, 2'd2, 4'hD), 32'h8000_0000, 32'h8000_0000, 64'h0, 1'b0, "R6 wide");
        check("R6 wide value", result, 64'h7FFF_FFFF_FFFF_FFFF);

        // R9: flag sticks through a non-saturating op
        issue(mk_instr(0, 2'd2, 4'hD), 32'd3, 32'd4, 64'h0, 1'b0, "R9 sticky");
        check("R9 sticky held", 64'(sat_flag), 64'd1);
        // R10: outputs hold and out_valid drops with no request
        held = result;
        @(negedge clk);
        check("R10 valid drop", 64'(out_valid), 64'd0);
        check("R10 result hold", result, held);
        clear_sat();
        // R9: clamp in the same cycle as clear keeps the flag set
        issue(mk_instr(0, 2'd1, 4'hD), 32'h8000, 32'h8000, 64'h0, 1'b1, "R9 clear+clamp");
        check("R9 set wins", 64'(sat_flag), 64'd1);

        // R1 R2 R3: sweep every U / size / opcode combination (sat flag is 1 here)
        for (int u = 0; u < 2; u++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int op = 0; op < 16; op++) begin
                    string tag;
                    if (u == 1) tag = "R1";
                    else if (sz == 0 || sz == 3) tag = "R3";
                    else tag = "R2";
                    issue(mk_instr(u[0], sz[1:0], op[3:0]), 32'h0000_1234, 32'h0000_5678,
                          64'h0000_0000_0000_0042, 1'b0, tag);
                end
            end
        end
        // R3: undefined ops did not touch the flag
        check("R3 sat untouched", 64'(sat_flag), 64'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule